// File: doc/BRIEF.md
# NAND Device Bus Front-End

This block is the device-side logic of a byte-wide storage interface. Commands, addresses and data share one 8-bit bus, and the latch-enable strobes decide what each byte is. A rising edge on the write strobe lands the byte in the command register, in one of four address bytes, or in the page register. A falling edge on the read strobe serves the byte at the current column and moves the column on. A ready/busy flag reports whether a read, program or erase is running.

The strobes are sampled by the block clock, so the clock must be several times faster than the strobe toggle rate. The storage array and the real program and erase algorithms are not modelled. A confirmed operation only holds the busy flag low for a number of clock cycles set by a parameter, and the page register keeps its contents through it.

Top module: `nand_bus_frontend`

## Requirements
- R1: With `ce_n` low, `cle` high, `ale` low and not busy, a rising edge of `we_n` stores `io_in` as the command. The operations are started by confirm/setup pairs: setup 0x00 then confirm 0x30 (read), 0x80 then 0x10 (program), 0x60 then 0xD0 (erase). A confirm byte starts nothing unless the command stored just before it is its matching setup. After reset the stored command is 0xFF.
- R2: With `ale` high and `cle` low, address bytes are taken in the order column low, column high, row low, row high. `row_addr` shows {row high, row low}. The second byte loads the column pointer with {column high, column low}, or with 0 if that value is not below the page size. Any command resets the byte index. A fifth and later address byte is ignored.
- R3: With `cle` and `ale` both low, a rising edge of `we_n` writes `io_in` into the page register at the column pointer, then advances the pointer by one.
- R4: A falling edge of `re_n` puts the byte at the column pointer on `io_out`, visible from the next clock cycle. The pointer then advances by one.
- R5: The page holds PAGE_MAIN + PAGE_SPARE bytes (2048 + 64 = 2112 by default). A pointer at the last column wraps to 0 on the next read or write strobe.
- R6: After an accepted confirm, `rb_n` is low for exactly T_READ, T_PROG or T_ERASE clock cycles, counted from the clock edge that takes the confirm byte. It then returns high.
- R7: While busy, all write and read strobes are ignored: the page, the pointer and `io_out` are unchanged. Raising `ce_n` does not shorten the busy period.
- R8: While `wp_n` is low, the program and erase confirms start nothing and `rb_n` stays high.
- R9: `io_oe` is high only while `ce_n` and `re_n` are both low. While `ce_n` is high, every strobe is ignored.
- R10: After reset, `rb_n` is high, `io_out` is 0 and the column pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe, bytes taken on its rising edge |
| re_n | input | 1 | Read strobe, data served on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte from the shared bus |
| io_out | output | 8 | Byte to the shared bus |
| io_oe | output | 1 | Output driver enable for the bus |
| rb_n | output | 1 | Ready (high) / busy (low) |
| row_addr | output | 16 | Captured row address |

## Verification
The bench writes a full small page and continues past the last column. A pointer that fails to wrap would write outside the page or read stale data, and a wrap that comes one byte early would shift every later byte. Start columns at a mid-page value, at an out-of-range value and after an extra fifth address byte are read back; a bad index or clamp would start the read at the wrong byte. Busy lengths are counted cycle by cycle while the bench toggles every strobe and `ce_n` during the busy period. A block that accepts those strobes would alter the page or `io_out`. Confirms with write protect low, and confirms with no matching setup, must leave `rb_n` high; a loose decode would show a spurious busy period.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    localparam logic [7:0] OP_IDLE     = 8'hFF;
    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] OP_PG_SETUP = 8'h80;
    localparam logic [7:0] OP_PG_GO    = 8'h10;
    localparam logic [7:0] OP_ER_SETUP = 8'h60;
    localparam logic [7:0] OP_ER_GO    = 8'hD0;

    typedef enum logic [1:0] {
        BUSY_NONE  = 2'd0,
        BUSY_READ  = 2'd1,
        BUSY_PROG  = 2'd2,
        BUSY_ERASE = 2'd3
    } busy_kind_e;

    typedef struct packed {
        logic [7:0] row_hi;
        logic [7:0] row_lo;
        logic [7:0] col_hi;
        logic [7:0] col_lo;
    } addr_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic busy_kind_e decode_go(input logic [7:0] prev,
                                             input logic [7:0] op,
                                             input logic       wp_n);
        if (prev == OP_RD_SETUP && op == OP_RD_GO)
            return BUSY_READ;
        if (prev == OP_PG_SETUP && op == OP_PG_GO && wp_n)
            return BUSY_PROG;
        if (prev == OP_ER_SETUP && op == OP_ER_GO && wp_n)
            return BUSY_ERASE;
        return BUSY_NONE;
    endfunction

endpackage

// File: rtl/nbf_edge.sv
module nbf_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = lvl & ~prev;
        end else begin : g_fall
            assign pulse = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/nbf_latch.sv
module nbf_latch
    import nbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_stb,
    input  logic        addr_stb,
    input  logic [7:0]  din,
    input  logic        wp_n,
    output busy_kind_e  go,
    output logic        col_load,
    output logic [15:0] col_val,
    output logic [15:0] row_addr
);
    localparam int ADDR_BYTES = 4;

    logic [7:0] last_cmd;
    logic [2:0] idx;
    addr_t      addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd <= OP_IDLE;
            idx      <= '0;
            addr     <= '0;
        end else if (cmd_stb) begin
            last_cmd <= din;
            idx      <= '0;
        end else if (addr_stb && idx < 3'(ADDR_BYTES)) begin
            case (idx)
                3'd0:    addr.col_lo <= din;
                3'd1:    addr.col_hi <= din;
                3'd2:    addr.row_lo <= din;
                default: addr.row_hi <= din;
            endcase
            idx <= idx + 3'd1;
        end
    end

    assign go       = cmd_stb ? decode_go(last_cmd, din, wp_n) : BUSY_NONE;
    assign col_load = addr_stb && (idx == 3'd1);
    assign col_val  = {din, addr.col_lo};
    assign row_addr = {addr.row_hi, addr.row_lo};

    // R2: address bytes past the fourth leave the captured address untouched
    p_extra_addr_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_stb && !cmd_stb && idx == 3'(ADDR_BYTES)) |=> (addr == $past(addr)));
endmodule

// File: rtl/nbf_page.sv
module nbf_page #(
    parameter int PAGE_BYTES = 2112,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [7:0]       din,
    input  logic             load,
    input  logic [15:0]      load_val,
    output logic [7:0]       dout
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

    logic [7:0]       mem [PAGE_BYTES];
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] col_next;

    assign col_next = (col == COL_LAST) ? '0 : col + 1'b1;

    always_ff @(posedge clk) begin
        if (wr_stb) mem[col] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= '0;
            dout <= '0;
        end else if (wr_stb) begin
            col <= col_next;
        end else if (rd_stb) begin
            dout <= mem[col];
            col  <= col_next;
        end else if (load) begin
            col <= (int'(load_val) < PAGE_BYTES) ? load_val[COL_W-1:0] : '0;
        end
    end

    // R5: the last column wraps to zero on any strobe
    p_col_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        ((wr_stb || rd_stb) && col == COL_LAST) |=> (col == '0));

    // R3: a strobe below the last column steps by exactly one
    p_col_step_r3: assert property (@(posedge clk) disable iff (rst)
        ((wr_stb || rd_stb) && col != COL_LAST) |=> (col == $past(col) + 1'b1));
endmodule

// File: rtl/nbf_busy.sv
module nbf_busy
    import nbf_pkg::*;
#(
    parameter int T_READ  = 25,
    parameter int T_PROG  = 200,
    parameter int T_ERASE = 1500,
    localparam int T_MAX  = max3(T_READ, T_PROG, T_ERASE),
    localparam int CNT_W  = $clog2(T_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  busy_kind_e start,
    output logic       busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            case (start)
                BUSY_READ:  cnt <= CNT_W'(T_READ);
                BUSY_PROG:  cnt <= CNT_W'(T_PROG);
                BUSY_ERASE: cnt <= CNT_W'(T_ERASE);
                default:    cnt <= '0;
            endcase
        end
    end

    assign busy = (cnt != '0);

    // R6: busy persists until the count runs out
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != CNT_W'(1)) |=> busy);

    // R8: without an accepted start the block stays ready
    p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start == BUSY_NONE) |=> !busy);
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
    import nbf_pkg::*;
#(
    parameter int PAGE_MAIN  = 2048,
    parameter int PAGE_SPARE = 64,
    parameter int T_READ     = 25,
    parameter int T_PROG     = 200,
    parameter int T_ERASE    = 1500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        cle,
    input  logic        ale,
    input  logic        we_n,
    input  logic        re_n,
    input  logic        wp_n,
    input  logic [7:0]  io_in,
    output logic [7:0]  io_out,
    output logic        io_oe,
    output logic        rb_n,
    output logic [15:0] row_addr
);
    localparam int PAGE_BYTES = PAGE_MAIN + PAGE_SPARE;

    logic       we_rise, re_fall, busy, en;
    logic       cmd_stb, addr_stb, wr_stb, rd_stb;
    logic       col_load;
    logic [15:0] col_val;
    busy_kind_e go;

    nbf_edge #(.RISING(1'b1)) u_we_edge (
        .clk(clk), .rst(rst), .lvl(we_n), .pulse(we_rise));
    nbf_edge #(.RISING(1'b0)) u_re_edge (
        .clk(clk), .rst(rst), .lvl(re_n), .pulse(re_fall));

    assign en       = !ce_n && !busy;
    assign cmd_stb  = we_rise && en &&  cle && !ale;
    assign addr_stb = we_rise && en && !cle &&  ale;
    assign wr_stb   = we_rise && en && !cle && !ale;
    assign rd_stb   = re_fall && en;

    nbf_latch u_latch (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
        .din(io_in), .wp_n(wp_n), .go(go), .col_load(col_load),
        .col_val(col_val), .row_addr(row_addr));

    nbf_page #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .din(io_in), .load(col_load), .load_val(col_val), .dout(io_out));

    nbf_busy #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) u_busy (
        .clk(clk), .rst(rst), .start(go), .busy(busy));

    assign rb_n  = !busy;
    assign io_oe = !ce_n && !re_n;

    // R7: while busy, the served byte never changes
    p_busy_freezes_out_r7: assert property (@(posedge clk) disable iff (rst)
        (!rb_n) |=> $stable(io_out));

    // R8: a protected program or erase confirm leaves the block ready
    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && !wp_n && rb_n && (io_in == OP_PG_GO || io_in == OP_ER_GO)) |=> rb_n);
endmodule

// File: tb/nand_bus_frontend_test.sv
module nand_bus_frontend_test;
    localparam int PM = 16, PS = 4, PB = PM + PS;
    localparam int TR = 5, TP = 7, TE = 11;

    logic clk = 1'b0;
    logic rst, ce_n, cle, ale, we_n, re_n, wp_n;
    logic [7:0]  io_in, io_out;
    logic        io_oe, rb_n;
    logic [15:0] row_addr;

    int checks = 0, fails = 0, mcol = 0;
    logic [7:0] model [PB];
    bit done = 0;

    always #2 clk = ~clk;

    nand_bus_frontend #(.PAGE_MAIN(PM), .PAGE_SPARE(PS), .T_READ(TR),
                        .T_PROG(TP), .T_ERASE(TE)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .rb_n(rb_n), .row_addr(row_addr));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wpulse(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  wpulse(1'b1, 1'b0, b); endtask
    task automatic addr(input logic [7:0] b); wpulse(1'b0, 1'b1, b); endtask

    task automatic wdat(input logic [7:0] b);
        wpulse(1'b0, 1'b0, b);
        model[mcol] = b;
        mcol = (mcol == PB - 1) ? 0 : mcol + 1;
    endtask

    task automatic rdat(input string tag);
        re_n = 1'b0;
        @(negedge clk);
        chk(io_out == model[mcol], tag, io_out, model[mcol]);
        re_n = 1'b1;
        @(negedge clk);
        mcol = (mcol == PB - 1) ? 0 : mcol + 1;
    endtask

    task automatic busy_len(input int exp, input string tag);
        int n = 0;
        while (!rb_n && n < 1000) begin n++; @(negedge clk); end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic start_read(input logic [7:0] lo, input logic [7:0] hi, input int col);
        cmd(8'h00); addr(lo); addr(hi); addr(8'h00); addr(8'h00);
        cmd(8'h30);
        busy_len(TR, "R6 read busy length");
        mcol = col;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1;
        re_n = 1'b1; wp_n = 1'b1; io_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(rb_n == 1'b1, "R10 rb_n after reset", rb_n, 1);
        chk(io_out == 8'h00, "R10 io_out after reset", io_out, 0);
        chk(io_oe == 1'b0, "R9 io_oe with ce_n high", io_oe, 0);
        ce_n = 1'b0;

        // R3/R5: fill the whole page and two more bytes past the end
        cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h34); addr(8'h12);
        chk(row_addr == 16'h1234, "R2 row address", row_addr, 16'h1234);
        mcol = 0;
        for (int i = 0; i < PB; i++) wdat(8'((i * 7 + 3) & 8'hFF));
        wdat(8'hA5); wdat(8'h5A);
        cmd(8'h10);
        busy_len(TP, "R6 program busy length");

        // R4/R5: read all from column 0 and wrap past the end
        start_read(8'h00, 8'h00, 0);
        for (int i = 0; i < PB + 2; i++) rdat("R4 R5 page readback");
        re_n = 1'b0; #1;
        chk(io_oe == 1'b1, "R9 io_oe with ce_n and re_n low", io_oe, 1);
        ce_n = 1'b1; #1;
        chk(io_oe == 1'b0, "R9 io_oe after ce_n rises", io_oe, 0);
        @(negedge clk); re_n = 1'b1; @(negedge clk); ce_n = 1'b0;

        // R2: mid-page start, out-of-range start, index reset, fifth byte
        start_read(8'(PB - 5), 8'h00, PB - 5);
        for (int i = 0; i < 7; i++) rdat("R2 mid-page start");
        start_read(8'h00, 8'h01, 0);
        rdat("R2 out-of-range column loads 0");
        cmd(8'h00); addr(8'h05); cmd(8'h00); addr(8'h02); addr(8'h00);
        addr(8'h00); addr(8'h00); addr(8'h09);
        cmd(8'h30); busy_len(TR, "R6 read busy length"); mcol = 2;
        rdat("R2 command resets index and fifth byte ignored");
        rdat("R2 next byte");

        // R8: write protect blocks program and erase
        wp_n = 1'b0;
        cmd(8'h80); addr(8'h00); addr(8'h00); cmd(8'h10);
        chk(rb_n == 1'b1, "R8 program blocked", rb_n, 1);
        cmd(8'h60); addr(8'h00); addr(8'h00); cmd(8'hD0);
        chk(rb_n == 1'b1, "R8 erase blocked", rb_n, 1);
        wp_n = 1'b1;

        // R1: confirms with no matching setup start nothing
        cmd(8'h30);
        chk(rb_n == 1'b1, "R1 read confirm after erase confirm", rb_n, 1);
        cmd(8'h80); cmd(8'hD0);
        chk(rb_n == 1'b1, "R1 erase confirm after program setup", rb_n, 1);

        // R7: erase busy while every strobe toggles
        begin
            logic [7:0] held;
            int n = 0;
            held = io_out;
            cmd(8'h60); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00);
            cmd(8'hD0);
            io_in = 8'hEE;
            while (!rb_n && n < 1000) begin
                ce_n = n[0]; we_n = n[1]; re_n = n[2];
                n++;
                @(negedge clk);
            end
            ce_n = 1'b1; @(negedge clk);
            we_n = 1'b1; re_n = 1'b1; @(negedge clk);
            ce_n = 1'b0;
            chk(n == TE, "R6 R7 erase busy length with strobes", n, TE);
            chk(io_out == held, "R7 io_out frozen while busy", io_out, held);
        end

        // R9: strobes with ce_n high are ignored
        ce_n = 1'b1;
        wpulse(1'b0, 1'b0, 8'h77);
        wpulse(1'b1, 1'b0, 8'h00);
        ce_n = 1'b0;
        chk(rb_n == 1'b1, "R9 no busy from deselected strobes", rb_n, 1);
        start_read(8'h00, 8'h00, 0);
        for (int i = 0; i < PB; i++) rdat("R7 R9 page unchanged");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule